// File: doc/BRIEF.md
# Markov Miss-Successor Prefetch Table

This block watches the stream of translation misses and learns, for each missing virtual page, which pages tended to miss next. Each row of a direct-mapped table is selected by the low bits of the virtual page number and tagged with the remaining bits. A row holds a short list of successor pages kept in recency order. When a miss arrives, the block looks up the row of the missing page. If the tag matches, it sends each recorded successor out as a prefetch request, one per cycle, most recently used first. The demand page walk runs in parallel, and the requester can resume as soon as the demand translation returns. The prefetches complete in the background into a buffer that sits beside the TLB.

The block learns in the same cycle. It keeps the page of the previous miss, and it places the current page at the front of that page's list. A page that is already in the list moves to the front and is not written twice. If the list has a free slot, the new page takes it. If the list is full, the least recently used successor drops out. When the tag does not match, the row is claimed afresh with an empty list, and no prefetch is sent. A new miss drops any requests that are still waiting.

Top module: `mkv_succ_prefetch`

## Requirements
- R1: After reset no prefetch is pending, every row is empty and no previous miss is held, so the first miss after reset teaches nothing and produces no prefetch.
- R2: A miss whose row tag does not match (or whose row is empty) produces no prefetch; pf_valid is low in the cycle after the miss.
- R3: A miss whose row tag matches presents its first successor on pf_vpn with pf_valid high in the cycle after the miss. Each following successor appears one cycle after the previous one is accepted (pf_valid and pf_ready both high).
- R4: On each miss with a previous miss held, the current page becomes slot 0 (most recently used) of the previous page's row, provided that row still carries the previous page's tag.
- R5: While a row has a free slot, inserting a new successor keeps every existing successor, each moved back by one position.
- R6: When a row's SLOTS slots are full, inserting a new successor discards the least recently used one.
- R7: Inserting a page that is already in the row moves it to slot 0 without duplicating it. The other entries keep their relative order.
- R8: While pf_valid is high and pf_ready is low, pf_valid stays high and pf_vpn holds its value until a new miss arrives.
- R9: A miss that arrives while requests are pending cancels the rest. Only the new miss's successors are issued afterwards.
- R10: The row index is miss_vpn[IDX_W-1:0] and the tag is the remaining upper bits. A page that maps to the same row with a different tag claims the row and erases the old successors.
- R11: At most SLOTS requests are accepted per miss, and pf_valid falls once the list is drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | One-cycle strobe for a translation miss |
| miss_vpn | input | VPN_W | Virtual page number of the miss |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The consumer accepts the offered request |
| pf_vpn | output | VPN_W | Virtual page number to prefetch |

## Verification
A corrupted successor list would show up at the ports as the wrong pages, or as pages in the wrong order, on the very next miss to that page. It would appear in the first cycle after that miss. A wrong tag or index would show as missing or unexpected prefetches when pages alias. A fault in the previous-page register would send what is learned to the wrong row. That error only appears at the next miss of the page that should have learned, so the sweeps revisit a small set of pages often, to keep that delay short.

// File: rtl/mkv_pkg.sv
package mkv_pkg;
    localparam int unsigned MKV_VPN_W = 36;
    localparam int unsigned MKV_IDX_W = 8;
    localparam int unsigned MKV_SLOTS = 2;
endpackage

// File: rtl/mkv_row_store.sv
module mkv_row_store #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned ROW_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    output logic [ROW_W-1:0] ra_row,
    output logic             ra_live,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [ROW_W-1:0] rb_row,
    output logic             rb_live,
    input  logic             wa_en,
    input  logic [IDX_W-1:0] wa_idx,
    input  logic [ROW_W-1:0] wa_row,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic [ROW_W-1:0] wb_row
);
    localparam int unsigned ROWS = 1 << IDX_W;

    logic [ROW_W-1:0] mem [ROWS];
    logic [ROWS-1:0]  live_d, live_q;

    always_comb begin
        live_d = live_q;
        if (wb_en) live_d[wb_idx] = 1'b1;
        if (wa_en) live_d[wa_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end

    // port a (row claim) is written last so it wins when both hit one row
    always_ff @(posedge clk) begin
        if (wb_en) mem[wb_idx] <= wb_row;
        if (wa_en) mem[wa_idx] <= wa_row;
    end

    assign ra_row  = mem[ra_idx];
    assign ra_live = live_q[ra_idx];
    assign rb_row  = mem[rb_idx];
    assign rb_live = live_q[rb_idx];
endmodule

// File: rtl/mkv_slot_promote.sv
module mkv_slot_promote #(
    parameter int unsigned VPN_W = 36,
    parameter int unsigned SLOTS = 2
) (
    input  logic [SLOTS*VPN_W-1:0] in_vpn,
    input  logic [SLOTS-1:0]       in_vld,
    input  logic [VPN_W-1:0]       new_vpn,
    output logic [SLOTS*VPN_W-1:0] out_vpn,
    output logic [SLOTS-1:0]       out_vld
);
    int   cut;
    logic found;

    always_comb begin
        found = 1'b0;
        cut   = SLOTS - 1;
        for (int k = 0; k < SLOTS; k++) begin
            if (!found && in_vld[k] && in_vpn[k*VPN_W +: VPN_W] == new_vpn) begin
                found = 1'b1;
                cut   = k;
            end
        end
        out_vpn = in_vpn;
        out_vld = in_vld;
        out_vpn[VPN_W-1:0] = new_vpn;
        out_vld[0]         = 1'b1;
        for (int k = 1; k < SLOTS; k++) begin
            if (k <= cut) begin
                out_vpn[k*VPN_W +: VPN_W] = in_vpn[(k-1)*VPN_W +: VPN_W];
                out_vld[k]                = in_vld[k-1];
            end
        end
    end
endmodule

// File: rtl/mkv_pf_issue.sv
module mkv_pf_issue #(
    parameter int unsigned VPN_W = 36,
    parameter int unsigned SLOTS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [SLOTS*VPN_W-1:0] load_vpn,
    input  logic [SLOTS-1:0]       load_vld,
    input  logic                   pf_ready,
    output logic                   pf_valid,
    output logic [VPN_W-1:0]       pf_vpn
);
    typedef struct packed {
        logic [SLOTS-1:0]       vld;
        logic [SLOTS*VPN_W-1:0] vpn;
    } list_t;

    list_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.vld[0] && pf_ready) begin
            st_d.vld = st_q.vld >> 1;
            st_d.vpn = st_q.vpn >> VPN_W;
        end
        if (load) begin
            st_d.vld = load_vld;
            st_d.vpn = load_vpn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pf_valid = st_q.vld[0];
    assign pf_vpn   = st_q.vpn[VPN_W-1:0];

    // R8: an offered request is held until taken or replaced
    p_hold_offer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !load) |=> (pf_valid && $stable(pf_vpn)));
endmodule

// File: rtl/mkv_succ_prefetch.sv
module mkv_succ_prefetch
    import mkv_pkg::*;
#(
    parameter int unsigned VPN_W = MKV_VPN_W,
    parameter int unsigned IDX_W = MKV_IDX_W,
    parameter int unsigned SLOTS = MKV_SLOTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic [VPN_W-1:0] miss_vpn,
    output logic             pf_valid,
    input  logic             pf_ready,
    output logic [VPN_W-1:0] pf_vpn
);
    localparam int unsigned TAG_W   = VPN_W - IDX_W;
    localparam int unsigned LIST_W  = SLOTS * VPN_W;
    localparam int unsigned ROW_W   = TAG_W + SLOTS + LIST_W;
    localparam int unsigned CNT_W   = $clog2(SLOTS + 2);

    typedef struct packed {
        logic             live;
        logic [VPN_W-1:0] vpn;
        logic [CNT_W-1:0] pops;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [ROW_W-1:0]  a_row, b_row, learn_row, fresh_row;
    logic              a_live, b_live;
    logic [IDX_W-1:0]  cur_idx, prev_idx;
    logic [TAG_W-1:0]  cur_tag, prev_tag;
    logic              cur_hit, learn_we, alloc_we;
    logic [LIST_W-1:0] learn_vpn;
    logic [SLOTS-1:0]  learn_vld, load_vld;
    logic              dup_found;

    assign cur_idx  = miss_vpn[IDX_W-1:0];
    assign cur_tag  = miss_vpn[VPN_W-1:IDX_W];
    assign prev_idx = st_q.vpn[IDX_W-1:0];
    assign prev_tag = st_q.vpn[VPN_W-1:IDX_W];

    mkv_row_store #(.IDX_W(IDX_W), .ROW_W(ROW_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (cur_idx),
        .ra_row (a_row),
        .ra_live(a_live),
        .rb_idx (prev_idx),
        .rb_row (b_row),
        .rb_live(b_live),
        .wa_en  (alloc_we),
        .wa_idx (cur_idx),
        .wa_row (fresh_row),
        .wb_en  (learn_we),
        .wb_idx (prev_idx),
        .wb_row (learn_row)
    );

    mkv_slot_promote #(.VPN_W(VPN_W), .SLOTS(SLOTS)) u_promote (
        .in_vpn (b_row[LIST_W-1:0]),
        .in_vld (b_row[LIST_W +: SLOTS]),
        .new_vpn(miss_vpn),
        .out_vpn(learn_vpn),
        .out_vld(learn_vld)
    );

    mkv_pf_issue #(.VPN_W(VPN_W), .SLOTS(SLOTS)) u_issue (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (miss_valid),
        .load_vpn(a_row[LIST_W-1:0]),
        .load_vld(load_vld),
        .pf_ready(pf_ready),
        .pf_valid(pf_valid),
        .pf_vpn  (pf_vpn)
    );

    always_comb begin
        cur_hit   = a_live && (a_row[ROW_W-1 -: TAG_W] == cur_tag);
        learn_we  = miss_valid && st_q.live && b_live
                    && (b_row[ROW_W-1 -: TAG_W] == prev_tag);
        alloc_we  = miss_valid && !cur_hit;
        learn_row = {prev_tag, learn_vld, learn_vpn};
        fresh_row = {cur_tag, {SLOTS{1'b0}}, {LIST_W{1'b0}}};
        load_vld  = cur_hit ? a_row[LIST_W +: SLOTS] : '0;

        st_d = st_q;
        if (miss_valid) begin
            st_d.live = 1'b1;
            st_d.vpn  = miss_vpn;
            st_d.pops = '0;
        end else if (pf_valid && pf_ready) begin
            st_d.pops = st_q.pops + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        dup_found = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            for (int j = i + 1; j < SLOTS; j++) begin
                if (learn_vld[i] && learn_vld[j]
                    && learn_vpn[i*VPN_W +: VPN_W] == learn_vpn[j*VPN_W +: VPN_W])
                    dup_found = 1'b1;
            end
        end
    end

    // R2: a row claimed afresh gives no prefetch
    p_tagmiss_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !cur_hit) |=> !pf_valid);

    // R3: a matching row with a successor offers slot 0 in the next cycle
    p_hit_offers_mru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && cur_hit && a_row[LIST_W]) |=>
        (pf_valid && pf_vpn == $past(a_row[VPN_W-1:0])));

    // R7: what is learned never holds one page twice
    p_no_dup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        learn_we |-> !dup_found);

    // R11: no more than SLOTS requests are taken per miss
    p_issue_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pops <= CNT_W'(SLOTS));
endmodule

// File: tb/sim_mkv_succ_prefetch.sv
`timescale 1ns/1ps
module sim_mkv_succ_prefetch;
    localparam int VW = 6;
    localparam int IW = 3;
    localparam int SL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [VW-1:0] miss_vpn = '0;
    logic          pf_valid;
    logic          pf_ready = 1'b0;
    logic [VW-1:0] pf_vpn;

    always #10 clk = ~clk;

    mkv_succ_prefetch #(.VPN_W(VW), .IDX_W(IW), .SLOTS(SL)) u0 (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_vpn(pf_vpn));

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state
    bit            mlive [8];
    logic [2:0]    mtag  [8];
    logic [VW-1:0] ms    [8][SL];
    bit            msv   [8][SL];
    logic [VW-1:0] prv;
    bit            prv_ok;
    int            exp_n;
    logic [VW-1:0] exp_l [SL];
    int            got_n;
    logic [VW-1:0] got_l [8];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 8; i++) begin
            mlive[i] = 1'b0;
            for (int k = 0; k < SL; k++) msv[i][k] = 1'b0;
        end
        prv_ok = 1'b0;
    endtask

    task automatic model_insert(input int r, input logic [VW-1:0] v);
        int pos;
        pos = -1;
        for (int k = 0; k < SL; k++)
            if (pos < 0 && msv[r][k] && ms[r][k] == v) pos = k;
        if (pos < 0) pos = SL - 1;
        for (int k = pos; k > 0; k--) begin
            ms[r][k]  = ms[r][k-1];
            msv[r][k] = msv[r][k-1];
        end
        ms[r][0]  = v;
        msv[r][0] = 1'b1;
    endtask

    task automatic model_step(input logic [VW-1:0] v);
        int  i, pi;
        bit  hit;
        i   = int'(v[IW-1:0]);
        hit = mlive[i] && mtag[i] == v[VW-1:IW];
        exp_n = 0;
        if (hit)
            for (int k = 0; k < SL; k++)
                if (msv[i][k]) begin exp_l[exp_n] = ms[i][k]; exp_n++; end
        pi = int'(prv[IW-1:0]);
        if (prv_ok && mlive[pi] && mtag[pi] == prv[VW-1:IW]) model_insert(pi, v);
        if (!hit) begin
            mlive[i] = 1'b1;
            mtag[i]  = v[VW-1:IW];
            for (int k = 0; k < SL; k++) msv[i][k] = 1'b0;
        end
        prv    = v;
        prv_ok = 1'b1;
    endtask

    task automatic do_miss(input logic [VW-1:0] v);
        @(negedge clk);
        pf_ready   = 1'b0;
        miss_valid = 1'b1;
        miss_vpn   = v;
        model_step(v);
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    // mode 0: always ready, 1: every other cycle, 2: one cycle in three
    task automatic drain(input string req, input int mode);
        bit            stall;
        logic [VW-1:0] held;
        bit            r;
        stall = 1'b0;
        held  = '0;
        got_n = 0;
        for (int c = 0; c < 4*SL + 6; c++) begin
            r = (mode == 0) ? 1'b1 : (mode == 1) ? c[0] : (c % 3 == 2);
            pf_ready = r;
            if (stall) chk(pf_valid && pf_vpn == held, "R8", int'(pf_vpn), int'(held));
            if (pf_valid && r && got_n < 8) begin
                got_l[got_n] = pf_vpn;
                got_n++;
            end
            stall = pf_valid && !r;
            held  = pf_vpn;
            @(negedge clk);
        end
        pf_ready = 1'b0;
        chk(got_n == exp_n, {req, "/R11 count"}, got_n, exp_n);
        chk(!pf_valid, "R11 idle", int'(pf_valid), 0);
        for (int k = 0; k < SL; k++)
            if (k < exp_n && k < got_n)
                chk(got_l[k] == exp_l[k], req, int'(got_l[k]), int'(exp_l[k]));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R3 actual=timeout expected=finished");
        summary();
    end

    initial begin
        logic [15:0] lfsr;
        logic [VW-1:0] first;
        model_clear();
        repeat (3) @(negedge clk);
        chk(!pf_valid, "R1 reset", int'(pf_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pf_valid, "R1 after reset", int'(pf_valid), 0);

        // directed: pages 1..4 share tag 0
        do_miss(6'd1); drain("R1", 0);
        do_miss(6'd2); drain("R2", 0);
        do_miss(6'd1); drain("R3", 0);
        chk(got_n == 1 && got_l[0] == 6'd2, "R4 learned", int'(got_l[0]), 2);
        do_miss(6'd3); drain("R2", 1);
        do_miss(6'd1); drain("R5", 1);
        chk(got_l[0] == 6'd3 && got_l[1] == 6'd2, "R5 order", int'(got_l[1]), 2);
        do_miss(6'd4); drain("R2", 0);
        do_miss(6'd1); drain("R6", 2);
        chk(got_l[0] == 6'd4 && got_l[1] == 6'd3, "R6 evict", int'(got_l[1]), 3);
        do_miss(6'd3); drain("R3", 0);
        do_miss(6'd1); drain("R7", 0);
        chk(got_n == 2 && got_l[0] == 6'd3 && got_l[1] == 6'd4, "R7 promote",
            int'(got_l[1]), 4);

        // R10: page 9 lands on row 1 with tag 1
        do_miss(6'd9); drain("R10", 0);
        do_miss(6'd1); drain("R10", 0);
        chk(got_n == 0, "R10 erased", got_n, 0);

        // R9: cancel a half-issued list
        do_miss(6'd2); drain("R3", 0);
        do_miss(6'd1); drain("R3", 0);
        do_miss(6'd3); drain("R3", 0);
        do_miss(6'd1);
        first = exp_l[0];
        chk(pf_valid && pf_vpn == first, "R3 next cycle", int'(pf_vpn), int'(first));
        pf_ready = 1'b1;
        @(negedge clk);
        pf_ready = 1'b0;
        chk(pf_valid && pf_vpn == 6'd2, "R3 second", int'(pf_vpn), 2);
        do_miss(6'd2); drain("R9", 0);
        chk(got_n == 1 && got_l[0] == 6'd1, "R9 replaced", int'(got_l[0]), 1);

        // R1: a second reset forgets rows and the previous page
        @(negedge clk);
        rst_n = 1'b0;
        model_clear();
        @(negedge clk);
        rst_n = 1'b1;
        do_miss(6'd1); drain("R1", 0);
        do_miss(6'd2); drain("R1", 0);
        do_miss(6'd1); drain("R1", 0);
        chk(got_n == 1 && got_l[0] == 6'd2, "R1 fresh", got_n, 1);

        // sweep over small page sets, with and without aliasing
        lfsr = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i < 1200) do_miss(lfsr[5:0] & 6'b001111);
            else          do_miss(lfsr[5:0]);
            drain("R3 sweep", i % 3);
        end
        summary();
    end
endmodule